// File: doc/BRIEF.md
# Processor interrupt request controller

This block sits beside the execution core of a small processor. It collects the hardware interrupt sources and each cycle reports the single request that may be serviced now, with its source code and fixed vector address. The sources are:

- a non-maskable trap input;
- three restart inputs, where the 5.5 and 6.5 restarts are level-sensitive and the 7.5 restart is edge-triggered;
- one general interrupt request.

The core drives commands into the block. It raises enable and disable commands for the global interrupt-enable flag. It writes a control byte to change the restart masks, and it reads back a status byte. When the core enters a service sequence, it pulses the acknowledge input with the source code of the request it took. The block then updates only the state that belongs to that source.

Two sources capture edges and need care. The 7.5 restart latch stays visible in the status byte even while the 7.5 restart is masked, and three separate events clear it. The trap must have a captured rising edge, and its level must still be high when it is serviced.

Top module: `intr_gate_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block sets all three mask bits to 1. It also clears the global enable, the trap latch, the 7.5 restart latch and `gen_ack`. After reset, with all inputs low, `mask_rdata` reads 0x07 and `req_valid` is 0.
- R2: A cycle with `mask_wr` high updates the mask from `mask_wdata[2:0]` only when `mask_wdata[3]` is 1. If `mask_wdata[3]` is 0, the mask is unchanged. `mask_wdata[7:5]` has no effect on any state.
- R3: While its mask bit is 1, a level restart cannot be serviced and does not show as pending. Mask bit 0 covers the 5.5 restart and mask bit 1 covers the 6.5 restart.
- R4: A rising edge on `rst75_in` sets the 7.5 restart latch whatever the mask. A level held high does not set the latch again. The latch can be serviced only while mask bit 2 is 0 and the global enable is 1.
- R5: The 7.5 restart latch clears on an acknowledge of source 4, on reset, or on a mask write with `mask_wdata[4]` = 1. The mask write clears the latch whatever the value of `mask_wdata[3]`.
- R6: `cmd_ei` sets the global enable. `cmd_di` clears it. An acknowledge of source 1, 2 or 3 also clears it. A clear wins over `cmd_ei` in the same cycle. An acknowledge of source 4 or 5 leaves the global enable unchanged.
- R7: A rising edge on `trap_in` sets the trap latch. The trap is requested only while the latch is set and `trap_in` is still high, whatever the mask or the global enable. An acknowledge of source 5 clears the latch.
- R8: `req_src` is the highest-priority serviceable source. The codes, from highest to lowest priority, are trap 5, 7.5 restart 4, 6.5 restart 3, 5.5 restart 2, general request 1, and none 0. `req_vector` is 0x24, 0x3C, 0x34 or 0x2C for sources 5 to 2, and 0x00 otherwise. `req_valid` is high exactly when `req_src` is not 0.
- R9: The general request is serviceable while `gen_req_in` is high and the global enable is 1. An acknowledge of source 1 makes `gen_ack` high for exactly the following cycle.
- R10: An acknowledge changes only the state of the source it names. The latches of other sources stay as they were.
- R11: `mask_rdata` has this layout. Bits 2:0 hold the mask. Bit 3 holds the global enable. Bit 4 is the 5.5 pending state, which is `rst55_in` with mask bit 0 clear. Bit 5 is the 6.5 pending state, which is `rst65_in` with mask bit 1 clear. Bit 6 is the 7.5 latch. Bit 7 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trap_in | input | 1 | Non-maskable trap line |
| rst75_in | input | 1 | Edge-triggered 7.5 restart line |
| rst65_in | input | 1 | Level 6.5 restart line |
| rst55_in | input | 1 | Level 5.5 restart line |
| gen_req_in | input | 1 | General interrupt request level |
| cmd_ei | input | 1 | Set global enable |
| cmd_di | input | 1 | Clear global enable |
| mask_wr | input | 1 | Set-mask write strobe |
| mask_wdata | input | 8 | Set-mask control byte |
| ack_in | input | 1 | Service acknowledge strobe |
| ack_src | input | 3 | Source code being acknowledged |
| mask_rdata | output | 8 | Read-mask status byte |
| req_valid | output | 1 | A serviceable request exists |
| req_src | output | 3 | Code of the selected request |
| req_vector | output | 8 | Vector address of the selected request |
| gen_ack | output | 1 | One-cycle strobe after a general-request acknowledge |

## Verification
The hardest states to reach from the ports combine captured edges with held levels and a masked 7.5 latch under a chosen enable. Examples are a trap edge whose level is still held, or a 7.5 latch that is set while masked. The bench reaches every such state by a fixed sequence after reset. It writes the mask byte first, then optionally raises the enable, then pulses `rst75_in`, then raises and holds `trap_in`, and finally applies the three level inputs. It sweeps all 512 combinations of these choices and checks each one against a priority function computed in the bench. Directed sequences then cover the clear paths and the same-cycle conflicts.

// File: rtl/intr_gate_pkg.sv
// Shared types and constants of the interrupt request controller.
// Assumes: the source codes are fixed, and the numeric order of the codes
// is the service priority (a larger code means a higher priority).
package intr_gate_pkg;

    localparam int SRC_W  = 3;
    localparam int VEC_W  = 8;
    localparam int CTRL_W = 8;
    localparam int MASK_W = 3;
    localparam int NSRC   = 5;

    // Bit positions in the set-mask control byte
    localparam int MASK_EN_BIT = 3;
    localparam int R75_CLR_BIT = 4;

    typedef enum logic [SRC_W-1:0] {
        SRC_NONE = 3'd0,
        SRC_GEN  = 3'd1,
        SRC_R55  = 3'd2,
        SRC_R65  = 3'd3,
        SRC_R75  = 3'd4,
        SRC_TRAP = 3'd5
    } intr_src_e;

    localparam logic [VEC_W-1:0] VEC_TRAP = 8'h24;
    localparam logic [VEC_W-1:0] VEC_R75  = 8'h3C;
    localparam logic [VEC_W-1:0] VEC_R65  = 8'h34;
    localparam logic [VEC_W-1:0] VEC_R55  = 8'h2C;
    localparam logic [VEC_W-1:0] VEC_NONE = 8'h00;

    // Map a source code to its fixed vector address
    function automatic logic [VEC_W-1:0] vec_of(input intr_src_e s);
        case (s)
            SRC_TRAP: vec_of = VEC_TRAP;
            SRC_R75:  vec_of = VEC_R75;
            SRC_R65:  vec_of = VEC_R65;
            SRC_R55:  vec_of = VEC_R55;
            default:  vec_of = VEC_NONE;
        endcase
    endfunction

endpackage

// File: rtl/intr_edge_latch.sv
// Rising-edge capture latch for one interrupt line.
// Assumes: level_i is already synchronous to clk. The previous-level register
// resets to 0, so a line that is high when reset is released counts as an edge.
// A new edge wins over a clear in the same cycle.
module intr_edge_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    input  logic clr_i,
    output logic latched_o
);

    logic prev_q;
    logic rise;

    // Detect a low-to-high transition against the last sampled level
    assign rise = level_i & ~prev_q;

    // Remember the line level of the last cycle
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= level_i;
    end

    // Hold the capture until a clear request arrives
    always_ff @(posedge clk) begin
        if (!rst_n)      latched_o <= 1'b0;
        else if (rise)   latched_o <= 1'b1;
        else if (clr_i)  latched_o <= 1'b0;
    end

endmodule

// File: rtl/intr_mask_regs.sv
// Mask register and global interrupt-enable flag.
// Assumes: the write byte uses a mask-enable bit that gates the mask field.
// Any clear of the enable wins over an enable command in the same cycle.
module intr_mask_regs
    import intr_gate_pkg::*;
#(
    parameter int MW = MASK_W,
    parameter int CW = CTRL_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_i,
    input  logic [CW-1:0] wdata_i,
    input  logic          ei_i,
    input  logic          di_i,
    input  logic          ack_clr_i,
    output logic [MW-1:0] mask_o,
    output logic          ie_o
);

    localparam logic [MW-1:0] MASK_RST = {MW{1'b1}};

    logic take_mask;
    logic ie_clr;

    assign take_mask = wr_i & wdata_i[MASK_EN_BIT];
    assign ie_clr    = di_i | ack_clr_i;

    // Load new mask bits only when the write enables them
    always_ff @(posedge clk) begin
        if (!rst_n)         mask_o <= MASK_RST;
        else if (take_mask) mask_o <= wdata_i[MW-1:0];
    end

    // Global enable: clear requests take precedence over an enable command
    always_ff @(posedge clk) begin
        if (!rst_n)      ie_o <= 1'b0;
        else if (ie_clr) ie_o <= 1'b0;
        else if (ei_i)   ie_o <= 1'b1;
    end

endmodule

// File: rtl/intr_prio_pick.sv
// Fixed-priority selector over the serviceable sources.
// Assumes: ok_i bit k belongs to the source with code k+1, and a higher
// index means a higher priority. Outputs 0 when no bit is set.
module intr_prio_pick #(
    parameter int N   = 5,
    parameter int SW  = $clog2(N + 1)
) (
    input  logic [N-1:0]  ok_i,
    output logic [SW-1:0] code_o
);

    // Scan upward so the highest set index is the last one written
    always_comb begin
        code_o = '0;
        for (int k = 0; k < N; k++) begin
            if (ok_i[k]) code_o = SW'(k + 1);
        end
    end

endmodule

// File: rtl/intr_gate_ctrl.sv
// Processor interrupt request controller (top).
// Collects the trap, the three restart lines and the general request. Keeps
// the mask, the global enable and the edge latches, and presents the
// highest-priority serviceable request with its vector. An acknowledge
// updates only the state of the named source.
// Assumes: all inputs are synchronous to clk. The core raises ack_in for one
// cycle for each service it performs.
module intr_gate_ctrl
    import intr_gate_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trap_in,
    input  logic              rst75_in,
    input  logic              rst65_in,
    input  logic              rst55_in,
    input  logic              gen_req_in,
    input  logic              cmd_ei,
    input  logic              cmd_di,
    input  logic              mask_wr,
    input  logic [CTRL_W-1:0] mask_wdata,
    input  logic              ack_in,
    input  logic [SRC_W-1:0]  ack_src,
    output logic [CTRL_W-1:0] mask_rdata,
    output logic              req_valid,
    output logic [SRC_W-1:0]  req_src,
    output logic [VEC_W-1:0]  req_vector
    ,
    output logic              gen_ack
);

    logic              trap_lat;
    logic              r75_lat;
    logic [MASK_W-1:0] mask;
    logic              ie;
    logic              ack_gen, ack_r55, ack_r65, ack_r75, ack_trap;
    logic              r75_clr;
    logic              pend55, pend65;
    logic [NSRC-1:0]   ok;
    logic [SRC_W-1:0]  pick;

    // Decode which source the acknowledge names
    always_comb begin
        ack_gen  = ack_in & (ack_src == SRC_GEN);
        ack_r55  = ack_in & (ack_src == SRC_R55);
        ack_r65  = ack_in & (ack_src == SRC_R65);
        ack_r75  = ack_in & (ack_src == SRC_R75);
        ack_trap = ack_in & (ack_src == SRC_TRAP);
    end

    // The 7.5 latch clears on its own acknowledge or on a write with the clear bit
    assign r75_clr = ack_r75 | (mask_wr & mask_wdata[R75_CLR_BIT]);

    intr_edge_latch u_trap_lat (
        .clk       (clk),
        .rst_n     (rst_n),
        .level_i   (trap_in),
        .clr_i     (ack_trap),
        .latched_o (trap_lat)
    );

    intr_edge_latch u_r75_lat (
        .clk       (clk),
        .rst_n     (rst_n),
        .level_i   (rst75_in),
        .clr_i     (r75_clr),
        .latched_o (r75_lat)
    );

    intr_mask_regs #(
        .MW (MASK_W),
        .CW (CTRL_W)
    ) u_mask (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (mask_wr),
        .wdata_i   (mask_wdata),
        .ei_i      (cmd_ei),
        .di_i      (cmd_di),
        .ack_clr_i (ack_gen | ack_r55 | ack_r65),
        .mask_o    (mask),
        .ie_o      (ie)
    );

    // Level restarts are visible only when their mask bit is clear
    assign pend55 = rst55_in & ~mask[0];
    assign pend65 = rst65_in & ~mask[1];

    // Serviceable flags, indexed by source code minus one
    always_comb begin
        ok[SRC_GEN  - 1] = gen_req_in & ie;
        ok[SRC_R55  - 1] = pend55 & ie;
        ok[SRC_R65  - 1] = pend65 & ie;
        ok[SRC_R75  - 1] = r75_lat & ~mask[2] & ie;
        ok[SRC_TRAP - 1] = trap_lat & trap_in;
    end

    intr_prio_pick #(
        .N  (NSRC),
        .SW (SRC_W)
    ) u_pick (
        .ok_i   (ok),
        .code_o (pick)
    );

    // Present the selected request and its vector
    always_comb begin
        req_src    = pick;
        req_valid  = (pick != SRC_NONE);
        req_vector = vec_of(intr_src_e'(pick));
    end

    // Assemble the read-mask status byte
    assign mask_rdata = {1'b0, r75_lat, pend65, pend55, ie, mask};

    // Strobe for the general request one cycle after its acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n) gen_ack <= 1'b0;
        else        gen_ack <= ack_gen;
    end

endmodule

// File: rtl/intr_gate_chk.sv
// Assertion checker for intr_gate_ctrl, attached by the bind at the end.
// Assumes: the source codes and the status layout defined in intr_gate_pkg.
module intr_gate_chk
    import intr_gate_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              trap_in,
    input logic              rst75_in,
    input logic              mask_wr,
    input logic [CTRL_W-1:0] mask_wdata,
    input logic              ack_in,
    input logic [SRC_W-1:0]  ack_src,
    input logic [CTRL_W-1:0] mask_rdata,
    input logic              req_valid,
    input logic [SRC_W-1:0]  req_src,
    input logic              gen_ack,
    input logic              trap_lat
);

    AST_RESET_STATE: assert property (@(posedge clk)
        !rst_n |=> (mask_rdata[3:0] == 4'b0111) && !mask_rdata[6] && !gen_ack); // R1

    AST_LOW_MASK_HIDES55: assert property (@(posedge clk) disable iff (!rst_n)
        mask_rdata[0] |-> !mask_rdata[4] && (req_src != SRC_R55)); // R3

    AST_LOW_MASK_HIDES65: assert property (@(posedge clk) disable iff (!rst_n)
        mask_rdata[1] |-> !mask_rdata[5] && (req_src != SRC_R65)); // R3

    AST_R75_MASK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        mask_rdata[2] |-> (req_src != SRC_R75)); // R4

    AST_R75_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        mask_wr && mask_wdata[R75_CLR_BIT] && !rst75_in |=> !mask_rdata[6]); // R5

    AST_IE_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        ack_in && (ack_src == SRC_GEN || ack_src == SRC_R55 || ack_src == SRC_R65)
        |=> !mask_rdata[3]); // R6

    AST_TRAP_NEEDS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (req_src == SRC_TRAP) |-> trap_in && trap_lat); // R7

    AST_TRAP_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        trap_lat && trap_in |-> (req_src == SRC_TRAP)); // R8

    AST_VALID_MATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid == (req_src != SRC_NONE)); // R8

    AST_GEN_ACK_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        ack_in && (ack_src == SRC_GEN) |=> gen_ack); // R9

    AST_STATUS_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_rdata[7]); // R11

endmodule

bind intr_gate_ctrl intr_gate_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .trap_in    (trap_in),
    .rst75_in   (rst75_in),
    .mask_wr    (mask_wr),
    .mask_wdata (mask_wdata),
    .ack_in     (ack_in),
    .ack_src    (ack_src),
    .mask_rdata (mask_rdata),
    .req_valid  (req_valid),
    .req_src    (req_src),
    .gen_ack    (gen_ack),
    .trap_lat   (trap_lat)
);

// File: tb/intr_gate_ctrl_tb.sv
// Self-checking bench: a full sweep of input setups plus directed sequences.
module intr_gate_ctrl_tb;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       trap_in = 0, rst75_in = 0, rst65_in = 0, rst55_in = 0, gen_req_in = 0;
    logic       cmd_ei = 0, cmd_di = 0, mask_wr = 0, ack_in = 0;
    logic [7:0] mask_wdata = 0;
    logic [2:0] ack_src = 0;
    logic [7:0] mask_rdata;
    logic       req_valid;
    logic [2:0] req_src;
    logic [7:0] req_vector;
    logic       gen_ack;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    intr_gate_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .trap_in(trap_in), .rst75_in(rst75_in),
        .rst65_in(rst65_in), .rst55_in(rst55_in), .gen_req_in(gen_req_in),
        .cmd_ei(cmd_ei), .cmd_di(cmd_di), .mask_wr(mask_wr), .mask_wdata(mask_wdata),
        .ack_in(ack_in), .ack_src(ack_src), .mask_rdata(mask_rdata),
        .req_valid(req_valid), .req_src(req_src), .req_vector(req_vector),
        .gen_ack(gen_ack)
    );

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic clear_inputs();
        trap_in = 0; rst75_in = 0; rst65_in = 0; rst55_in = 0; gen_req_in = 0;
        cmd_ei = 0; cmd_di = 0; mask_wr = 0; ack_in = 0; mask_wdata = 0; ack_src = 0;
    endtask

    task automatic do_reset();
        clear_inputs();
        rst_n = 0;
        step(); step();
        rst_n = 1;
    endtask

    task automatic write_mask(input logic [7:0] b);
        mask_wr = 1; mask_wdata = b;
        step();
        mask_wr = 0; mask_wdata = 0;
    endtask

    task automatic enable_ie();
        cmd_ei = 1; step(); cmd_ei = 0;
    endtask

    task automatic pulse_r75();
        rst75_in = 1; step(); rst75_in = 0;
    endtask

    task automatic ack(input logic [2:0] s);
        ack_in = 1; ack_src = s; step(); ack_in = 0; ack_src = 0;
    endtask

    // Expected source from the requirement rules (R8 priority)
    function automatic int exp_src(input int m, input int ie, input int gen,
                                   input int l55, input int l65, input int r75, input int trap);
        if (trap != 0)                                return 5;
        if (r75 != 0 && (m & 4) == 0 && ie != 0)      return 4;
        if (l65 != 0 && (m & 2) == 0 && ie != 0)      return 3;
        if (l55 != 0 && (m & 1) == 0 && ie != 0)      return 2;
        if (gen != 0 && ie != 0)                      return 1;
        return 0;
    endfunction

    function automatic int exp_vec(input int s);
        case (s)
            5: return 'h24;
            4: return 'h3C;
            3: return 'h34;
            2: return 'h2C;
            default: return 0;
        endcase
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        do_reset();
        step();
        chk("R1 status", mask_rdata, 'h07);
        chk("R1 valid", req_valid, 0);
        chk("R1 gen_ack", gen_ack, 0);

        // R8 R11 R3 R4 R7: sweep of all setups
        for (int c = 0; c < 512; c++) begin
            int m, ie, gen, l55, l65, r75, tr, s, st;
            m = c & 7; ie = (c >> 3) & 1; gen = (c >> 4) & 1; l55 = (c >> 5) & 1;
            l65 = (c >> 6) & 1; r75 = (c >> 7) & 1; tr = (c >> 8) & 1;
            do_reset();
            write_mask(8'(8 | m));
            if (ie != 0) enable_ie();
            if (r75 != 0) pulse_r75();
            trap_in = (tr != 0);
            rst55_in = (l55 != 0); rst65_in = (l65 != 0); gen_req_in = (gen != 0);
            step();
            s  = exp_src(m, ie, gen, l55, l65, r75, tr);
            st = m | (ie << 3) | ((l55 & ~m & 1) << 4) | ((l65 & ~(m >> 1) & 1) << 5) | (r75 << 6);
            chk("R8 src", req_src, s);
            chk("R8 vector", req_vector, exp_vec(s));
            chk("R8 valid", req_valid, (s != 0) ? 1 : 0);
            chk("R11 status", mask_rdata, st);
        end

        // R2: mask write gating and ignored upper bits
        do_reset();
        write_mask(8'h05);
        chk("R2 no enable bit", mask_rdata, 'h07);
        write_mask(8'hEA);
        chk("R2 upper bits ignored", mask_rdata, 'h02);

        // R3: masked level restarts, then unmasked
        do_reset();
        write_mask(8'h0B);
        enable_ie();
        rst55_in = 1; rst65_in = 1;
        step();
        chk("R3 masked status", mask_rdata, 'h0B);
        chk("R3 masked valid", req_valid, 0);
        write_mask(8'h08);
        chk("R3 unmasked status", mask_rdata, 'h38);
        chk("R3 unmasked src", req_src, 3);

        // R4: latch set while masked, serviced after unmask, no retrigger on held level
        do_reset();
        write_mask(8'h0F);
        enable_ie();
        pulse_r75();
        chk("R4 masked pending", mask_rdata, 'h4F);
        chk("R4 masked no request", req_valid, 0);
        write_mask(8'h08);
        chk("R4 serviced src", req_src, 4);
        chk("R4 vector", req_vector, 'h3C);
        rst75_in = 1; step(); step();
        ack(3'd4);
        step();
        chk("R4 held level no retrigger", mask_rdata[6], 0);
        chk("R10 ack of 7.5 keeps enable", mask_rdata[3], 1);
        rst75_in = 0; step();
        pulse_r75();
        chk("R4 new edge sets", mask_rdata[6], 1);

        // R5: clear by write bit 4 without mask-enable, and by reset
        write_mask(8'h10);
        chk("R5 write clears latch", mask_rdata[6], 0);
        chk("R5 mask unchanged", mask_rdata[2:0], 0);
        pulse_r75();
        do_reset();
        step();
        chk("R5 reset clears latch", mask_rdata[6], 0);

        // R6: enable flag commands and conflicts
        enable_ie();
        chk("R6 ei sets", mask_rdata[3], 1);
        cmd_di = 1; step(); cmd_di = 0;
        chk("R6 di clears", mask_rdata[3], 0);
        cmd_ei = 1; cmd_di = 1; step(); cmd_ei = 0; cmd_di = 0;
        chk("R6 clear wins", mask_rdata[3], 0);
        enable_ie();
        cmd_ei = 1; ack_in = 1; ack_src = 3'd2; step();
        cmd_ei = 0; ack_in = 0; ack_src = 0;
        chk("R6 ack 5.5 beats ei", mask_rdata[3], 0);
        enable_ie();
        ack(3'd3);
        chk("R6 ack 6.5 clears", mask_rdata[3], 0);

        // R7: trap needs edge and level, ignores mask and enable
        do_reset();
        trap_in = 1; step();
        chk("R7 trap with ie off", req_src, 5);
        chk("R7 trap vector", req_vector, 'h24);
        trap_in = 0; step();
        chk("R7 level dropped", req_valid, 0);
        trap_in = 1; step();
        chk("R7 level back", req_src, 5);
        ack(3'd5);
        chk("R7 ack clears", req_valid, 0);
        trap_in = 0; step();

        // R9: general request and acknowledge strobe
        do_reset();
        enable_ie();
        gen_req_in = 1; step();
        chk("R9 gen src", req_src, 1);
        chk("R9 gen vector", req_vector, 0);
        ack(3'd1);
        chk("R9 gen_ack high", gen_ack, 1);
        chk("R9 enable cleared", mask_rdata[3], 0);
        chk("R9 no request", req_valid, 0);
        step();
        chk("R9 gen_ack one cycle", gen_ack, 0);
        gen_req_in = 0;

        // R10: acknowledge of one source leaves other latches alone
        do_reset();
        write_mask(8'h0C);
        pulse_r75();
        trap_in = 1; step();
        ack(3'd2);
        chk("R10 7.5 kept", mask_rdata[6], 1);
        chk("R10 trap kept", req_src, 5);
        ack(3'd4);
        chk("R10 trap kept after 7.5 ack", req_src, 5);
        chk("R10 7.5 cleared", mask_rdata[6], 0);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule